// File: doc/BRIEF.md
# Byte-Lane Read Data Alignment Calibrator

This block sits behind the capture stage of a double-data-rate read path. Each fabric clock it receives four captured beats for every byte lane, and it works out how far each lane must be delayed so that a repeating eight-byte training sequence (FF, 00, AA, 55, 55, AA, 99, 66) lines up with its first byte on the earliest beat slot of a fabric word. It then presents the read data realigned by those delays.

A calibration run starts with a single-cycle request. The lanes are handled in turn. For the current lane, candidate delays are tried in a fixed order: a beat shift of 0 to 3 beats inside each whole-cycle delay of 0 to 2 cycles. The first candidate that shows the full eight-byte sequence on a configured number of consecutive repetitions is stored for that lane. A lane whose candidates all fail is stored with the reserved delay code. Once the last lane has been decided, a done flag rises and an error flag reports whether any lane failed.

Top module: `rdal_calibrator`

## Requirements
- R1: While reset is asserted, `cal_done`, `cal_err`, `slip_cnt`, `cyc_dly` and `aligned_word` are all zero, and `cur_lane` is 0.
- R2: Both `rd_word` and `aligned_word` are four equal slot fields. From the least significant end they are rise0, fall0, rise1 and fall1. Lane i's byte in slot k sits at bit `k*LANES*8 + i*8`, and slot order is time order.
- R3: For a clean lane, the stored beat shift is the smallest shift at cycle delay 0 that puts FF on rise0 and the rest of the sequence in beat order. A candidate is only taken after `REPS` complete two-cycle repetitions (first half FF 00 AA 55, then second half 55 AA 99 66).
- R4: A lane whose data never forms the sequence is marked failed: its cycle-delay field reads 3 and its beat-shift field reads 0. A corrupted byte (for example 54 in place of 55) or the sequence starting on rise1 is never accepted.
- R5: Lane i's cycle delay is reported in `cyc_dly[2i+1:2i]` and its beat shift in `slip_cnt[2i+1:2i]`. A passing lane's delay is 0, 1 or 2, and both fields stay constant while `cal_done` is high and no new request arrives.
- R6: `cur_lane` reads 0 in the first cycle of a run and only ever steps up by one, or back to 0 at a new run.
- R7: `cal_done` clears in the cycle after an accepted request, rises after the last lane is decided whatever the outcome, and holds until the next request. `cal_err` equals the OR over lanes of "delay field is 3".
- R8: `aligned_word` slot k of lane i, two cycles after a fabric word is captured, carries the lane's stream beat that lies `4*delay + shift` beats earlier than that slot. A failed lane passes its data through with zero beat delay.
- R9: A calibration request that arrives while a run is in progress is ignored, so the lane counter does not return to 0.
- R10: If a lane's data is corrupted throughout every beat-shift trial at cycle delay 0, the search continues to cycle delay 1. That lane is then stored with delay 1 and the matching beat shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_start | input | 1 | Single-cycle request to begin a calibration run |
| rd_word | input | 4*LANES*8 | Captured read beats, four slots per lane |
| aligned_word | output | 4*LANES*8 | Read beats after per-lane realignment |
| slip_cnt | output | 2*LANES | Stored beat shift, two bits per lane |
| cyc_dly | output | 2*LANES | Stored cycle delay per lane; 3 marks a failed lane |
| cur_lane | output | max(1,clog2(LANES)) | Lane currently under calibration |
| cal_done | output | 1 | Run finished |
| cal_err | output | 1 | At least one lane failed |

## Verification
Two events can land on the same clock edge: the match counter reaching its target and the expiry of the candidate's trial window. This happens when the correct candidate begins its trial on the second half of the sequence, which leaves exactly one spare cycle. The bench provokes it by sweeping lane offsets across all eight phases, so half of the lanes start their winning candidate on the wrong half. It then judges the stored delay: it must read 0, because a pass lost to window expiry would send the search on to cycle delay 1.

// File: rtl/rdal_pkg.sv
package rdal_pkg;
  localparam int BYTE_W    = 8;
  localparam int SLOTS     = 4;
  localparam int WIN_BEATS = 16;
  localparam int HALF_W    = SLOTS * BYTE_W;
  // first half FF 00 AA 55, second half 55 AA 99 66 (slot 0 in the low byte)
  localparam logic [HALF_W-1:0] HALF_LEAD = 32'h55AA_00FF;
  localparam logic [HALF_W-1:0] HALF_TAIL = 32'h6699_AA55;
  localparam logic [1:0] DLY_FAIL = 2'b11;
  localparam logic [1:0] DLY_MAX  = 2'd2;
  localparam logic [1:0] SHIFT_MAX = 2'd3;

  typedef enum logic [1:0] {
    CAL_IDLE   = 2'd0,
    CAL_SEARCH = 2'd1,
    CAL_DONE   = 2'd2
  } cal_state_e;
endpackage

// File: rtl/rdal_history.sv
module rdal_history
  import rdal_pkg::*;
#(
  parameter int LANES = 4,
  localparam int WORD_W = SLOTS * LANES * BYTE_W,
  localparam int LWIN_W = WIN_BEATS * BYTE_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [WORD_W-1:0]       rd_word,
  output logic [LANES*LWIN_W-1:0] lane_win
);
  localparam int DEPTH = WIN_BEATS / SLOTS;

  logic [WORD_W-1:0] hist_q [DEPTH];
  logic [WORD_W-1:0] hist_d [DEPTH];
  logic              cap_en;

  assign cap_en = 1'b1;

  always_comb begin
    hist_d[0] = rd_word;
    for (int i = 1; i < DEPTH; i++) hist_d[i] = hist_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
    end else if (cap_en) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= hist_d[i];
    end
  end

  // beat j of a lane window: j = 0 is the oldest beat, j = 15 the newest
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar j = 0; j < WIN_BEATS; j++) begin : g_beat
      assign lane_win[l*LWIN_W + j*BYTE_W +: BYTE_W] =
        hist_q[DEPTH-1 - j/SLOTS][(j%SLOTS)*LANES*BYTE_W + l*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/rdal_select.sv
module rdal_select
  import rdal_pkg::*;
#(
  localparam int LWIN_W = WIN_BEATS * BYTE_W
) (
  input  logic [LWIN_W-1:0] win,
  input  logic [1:0]        shift,
  input  logic [1:0]        dly,
  output logic [HALF_W-1:0] beats
);
  int delay_beats;

  always_comb begin
    if (dly == DLY_FAIL) delay_beats = 0;
    else                 delay_beats = int'(dly) * SLOTS + int'(shift);
    for (int k = 0; k < SLOTS; k++) begin
      beats[k*BYTE_W +: BYTE_W] =
        win[(WIN_BEATS - SLOTS + k - delay_beats)*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/rdal_tracker.sv
module rdal_tracker
  import rdal_pkg::*;
#(
  parameter int REPS = 4,
  localparam int CW = $clog2(REPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [HALF_W-1:0] beats,
  output logic              pass
);
  logic          want_tail_q, want_tail_d;
  logic [CW-1:0] reps_q, reps_d;

  always_comb begin
    want_tail_d = 1'b0;
    reps_d      = '0;
    if (clr) begin
      want_tail_d = 1'b0;
      reps_d      = '0;
    end else if (beats == HALF_LEAD) begin
      want_tail_d = 1'b1;
      reps_d      = want_tail_q ? '0 : reps_q;
    end else if (beats == HALF_TAIL && want_tail_q) begin
      want_tail_d = 1'b0;
      reps_d      = (reps_q == CW'(REPS)) ? reps_q : reps_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_tail_q <= 1'b0;
      reps_q      <= '0;
    end else begin
      want_tail_q <= want_tail_d;
      reps_q      <= reps_d;
    end
  end

  assign pass = (reps_q == CW'(REPS));
endmodule

// File: rtl/rdal_calibrator.sv
module rdal_calibrator
  import rdal_pkg::*;
#(
  parameter int LANES = 4,
  parameter int REPS  = 4,
  localparam int LW     = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int WORD_W = SLOTS * LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_start,
  input  logic [WORD_W-1:0] rd_word,
  output logic [WORD_W-1:0] aligned_word,
  output logic [2*LANES-1:0] slip_cnt,
  output logic [2*LANES-1:0] cyc_dly,
  output logic [LW-1:0]     cur_lane,
  output logic              cal_done,
  output logic              cal_err
);
  localparam int LWIN_W = WIN_BEATS * BYTE_W;
  localparam int WIN    = 2 * REPS + 2;
  localparam int TW     = $clog2(WIN + 1);

  cal_state_e          state_q, state_d;
  logic [LW-1:0]       lane_q, lane_d;
  logic [1:0]          cs_q, cs_d, cd_q, cd_d;
  logic [TW-1:0]       timer_q, timer_d;
  logic [2*LANES-1:0]  slip_q, slip_d, dly_q, dly_d;
  logic                trk_clr, trk_pass, lane_end, searching;
  logic [LANES*LWIN_W-1:0] lane_win;
  logic [LWIN_W-1:0]   cand_win;
  logic [HALF_W-1:0]   cand_beats;
  logic [WORD_W-1:0]   aligned_d, aligned_q;
  logic [LANES-1:0]    fail_vec;

  rdal_history #(.LANES(LANES)) u_hist (
    .clk(clk), .rst_n(rst_n), .rd_word(rd_word), .lane_win(lane_win)
  );

  assign cand_win = lane_win[int'(lane_q)*LWIN_W +: LWIN_W];

  rdal_select u_cand (
    .win(cand_win), .shift(cs_q), .dly(cd_q), .beats(cand_beats)
  );

  rdal_tracker #(.REPS(REPS)) u_trk (
    .clk(clk), .rst_n(rst_n), .clr(trk_clr), .beats(cand_beats), .pass(trk_pass)
  );

  // output realignment, one selector per lane using the stored settings
  for (genvar l = 0; l < LANES; l++) begin : g_out
    logic [HALF_W-1:0] lane_beats;
    rdal_select u_sel (
      .win(lane_win[l*LWIN_W +: LWIN_W]),
      .shift(slip_q[2*l +: 2]),
      .dly(dly_q[2*l +: 2]),
      .beats(lane_beats)
    );
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      assign aligned_d[k*LANES*BYTE_W + l*BYTE_W +: BYTE_W] = lane_beats[k*BYTE_W +: BYTE_W];
    end
    assign fail_vec[l] = (dly_q[2*l +: 2] == DLY_FAIL);
  end

  always_comb begin
    state_d  = state_q;
    lane_d   = lane_q;
    cs_d     = cs_q;
    cd_d     = cd_q;
    timer_d  = timer_q;
    slip_d   = slip_q;
    dly_d    = dly_q;
    trk_clr  = 1'b0;
    lane_end = 1'b0;
    case (state_q)
      CAL_SEARCH: begin
        timer_d = timer_q + 1'b1;
        if (trk_pass) begin
          slip_d[int'(lane_q)*2 +: 2] = cs_q;
          dly_d[int'(lane_q)*2 +: 2]  = cd_q;
          lane_end = 1'b1;
        end else if (timer_q == TW'(WIN - 1)) begin
          if (cs_q == SHIFT_MAX && cd_q == DLY_MAX) begin
            slip_d[int'(lane_q)*2 +: 2] = 2'd0;
            dly_d[int'(lane_q)*2 +: 2]  = DLY_FAIL;
            lane_end = 1'b1;
          end else begin
            trk_clr = 1'b1;
            timer_d = '0;
            if (cs_q == SHIFT_MAX) begin
              cs_d = 2'd0;
              cd_d = cd_q + 1'b1;
            end else begin
              cs_d = cs_q + 1'b1;
            end
          end
        end
        if (lane_end) begin
          trk_clr = 1'b1;
          timer_d = '0;
          cs_d    = 2'd0;
          cd_d    = 2'd0;
          if (lane_q == LW'(LANES - 1)) state_d = CAL_DONE;
          else                          lane_d  = lane_q + 1'b1;
        end
      end
      default: begin
        if (cal_start) begin
          state_d = CAL_SEARCH;
          lane_d  = '0;
          cs_d    = 2'd0;
          cd_d    = 2'd0;
          timer_d = '0;
          slip_d  = '0;
          dly_d   = '0;
          trk_clr = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= CAL_IDLE;
      lane_q    <= '0;
      cs_q      <= 2'd0;
      cd_q      <= 2'd0;
      timer_q   <= '0;
      slip_q    <= '0;
      dly_q     <= '0;
      aligned_q <= '0;
    end else begin
      state_q   <= state_d;
      lane_q    <= lane_d;
      cs_q      <= cs_d;
      cd_q      <= cd_d;
      timer_q   <= timer_d;
      slip_q    <= slip_d;
      dly_q     <= dly_d;
      aligned_q <= aligned_d;
    end
  end

  assign searching    = (state_q == CAL_SEARCH);
  assign aligned_word = aligned_q;
  assign slip_cnt     = slip_q;
  assign cyc_dly      = dly_q;
  assign cur_lane     = lane_q;
  assign cal_done     = (state_q == CAL_DONE);
  assign cal_err      = |fail_vec;
endmodule

// File: rtl/rdal_calibrator_chk.sv
module rdal_calibrator_chk #(
  parameter int LANES = 4,
  parameter int LW    = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cal_start,
  input logic               searching,
  input logic [LW-1:0]      cur_lane,
  input logic [2*LANES-1:0] slip_cnt,
  input logic [2*LANES-1:0] cyc_dly,
  input logic               cal_done,
  input logic               cal_err
);
  logic fail_any, fail_slip_bad;

  always_comb begin
    fail_any      = 1'b0;
    fail_slip_bad = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (cyc_dly[2*l +: 2] == 2'b11) begin
        fail_any = 1'b1;
        if (slip_cnt[2*l +: 2] != 2'b00) fail_slip_bad = 1'b1;
      end
    end
  end

  p_lane_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lane != $past(cur_lane)) |-> (cur_lane == LW'($past(cur_lane) + 1'b1) || cur_lane == '0));

  p_err_or_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cal_err == fail_any);

  p_fail_slip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fail_slip_bad);

  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && !cal_start) |=> cal_done);

  p_start_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_start && !searching) |=> (searching && !cal_done && cur_lane == '0));

  p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (searching && cal_start && cur_lane != '0) |=> (cur_lane != '0));

  p_stable_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && !cal_start) |=> ($stable(cyc_dly) && $stable(slip_cnt)));
endmodule

bind rdal_calibrator rdal_calibrator_chk #(.LANES(LANES), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .searching(searching),
  .cur_lane(cur_lane), .slip_cnt(slip_cnt), .cyc_dly(cyc_dly),
  .cal_done(cal_done), .cal_err(cal_err)
);

// File: tb/rdal_calibrator_test.sv
module rdal_calibrator_test;
  localparam int LANES = 4;
  localparam int REPS  = 4;
  localparam int LW    = 2;
  localparam int WW    = 4 * LANES * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_start = 1'b0;
  logic [WW-1:0] rd_word = '0;
  logic [WW-1:0] aligned_word;
  logic [2*LANES-1:0] slip_cnt, cyc_dly;
  logic [LW-1:0] cur_lane;
  logic cal_done, cal_err;

  int ecnt = 0;
  int offs [LANES];
  bit bad  [LANES];
  bit tmp_lane0 = 1'b0;
  int tmp_until = 0;
  int n_chk = 0;
  int n_fail = 0;
  int seed_sink;

  rdal_calibrator #(.LANES(LANES), .REPS(REPS)) uut (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .rd_word(rd_word),
    .aligned_word(aligned_word), .slip_cnt(slip_cnt), .cyc_dly(cyc_dly),
    .cur_lane(cur_lane), .cal_done(cal_done), .cal_err(cal_err)
  );

  always #4 clk = ~clk;
  always @(posedge clk) ecnt <= ecnt + 1;

  function automatic logic [7:0] pat_byte(int i);
    case (((i % 8) + 8) % 8)
      0: return 8'hFF;
      1: return 8'h00;
      2: return 8'hAA;
      3: return 8'h55;
      4: return 8'h55;
      5: return 8'hAA;
      6: return 8'h99;
      default: return 8'h66;
    endcase
  endfunction

  function automatic logic [7:0] beat_val(int l, int p, bit tmp);
    logic [7:0] b;
    b = pat_byte(p + offs[l]);
    if ((bad[l] || tmp) && b == 8'h55) b = 8'h54;
    return b;
  endfunction

  // stimulus: the word sampled at edge index ecnt carries stream beats 4*ecnt..4*ecnt+3
  initial begin
    forever begin
      @(negedge clk);
      for (int l = 0; l < LANES; l++)
        for (int k = 0; k < 4; k++)
          rd_word[k*LANES*8 + l*8 +: 8] <= beat_val(l, 4*ecnt + k, (l == 0 && ecnt < tmp_until));
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_cal(bit poke);
    int w;
    @(negedge clk) cal_start = 1'b1;
    @(negedge clk) cal_start = 1'b0;
    chk(cal_done == 1'b0, "R7", "done cleared after request", int'(cal_done), 0);
    chk(cur_lane == '0, "R6", "first lane", int'(cur_lane), 0);
    if (poke) begin
      w = 0;
      while (cur_lane != 2'd1 && w < 2000) begin @(negedge clk); w++; end
      cal_start = 1'b1;
      @(negedge clk) cal_start = 1'b0;
      chk(cur_lane != '0, "R9", "request during run ignored", int'(cur_lane), 1);
    end
    w = 0;
    while (!cal_done && w < 3000) begin @(negedge clk); w++; end
    chk(cal_done == 1'b1, "R7", "done after last lane", int'(cal_done), 1);
  endtask

  task automatic check_result();
    int es, ed, dsh;
    bit any_bad;
    logic [31:0] got, exp;
    any_bad = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      es = bad[l] ? 0 : offs[l] % 4;
      ed = bad[l] ? 3 : ((l == 0 && tmp_lane0) ? 1 : 0);
      any_bad |= bad[l];
      chk(int'(slip_cnt[2*l +: 2]) == es, bad[l] ? "R4" : "R3", "beat shift", int'(slip_cnt[2*l +: 2]), es);
      chk(int'(cyc_dly[2*l +: 2]) == ed, (l == 0 && tmp_lane0) ? "R10" : "R5", "cycle delay", int'(cyc_dly[2*l +: 2]), ed);
    end
    chk(cal_err == any_bad, "R7", "error flag", int'(cal_err), int'(any_bad));
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      for (int l = 0; l < LANES; l++) begin
        es  = bad[l] ? 0 : offs[l] % 4;
        ed  = bad[l] ? 3 : ((l == 0 && tmp_lane0) ? 1 : 0);
        dsh = (ed == 3) ? 0 : 4*ed + es;
        for (int k = 0; k < 4; k++) begin
          got[k*8 +: 8] = aligned_word[k*LANES*8 + l*8 +: 8];
          exp[k*8 +: 8] = beat_val(l, 4*(ecnt - 2) + k - dsh, 1'b0);
        end
        chk(got == exp, "R8", "aligned lane data (R2 layout)", int'(got), int'(exp));
      end
    end
  endtask

  task automatic prep(int o0, int o1, int o2, int o3);
    offs[0] = o0; offs[1] = o1; offs[2] = o2; offs[3] = o3;
    for (int l = 0; l < LANES; l++) bad[l] = 1'b0;
    tmp_lane0 = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    seed_sink = $urandom(32'd2718);
    for (int l = 0; l < LANES; l++) begin offs[l] = 0; bad[l] = 1'b0; end
    #2;
    chk(cal_done == 1'b0 && cal_err == 1'b0, "R1", "flags in reset", int'({cal_done, cal_err}), 0);
    chk(slip_cnt == '0 && cyc_dly == '0, "R1", "fields in reset", int'({slip_cnt, cyc_dly}), 0);
    chk(aligned_word == '0 && cur_lane == '0, "R1", "data in reset", int'(aligned_word[31:0]), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    prep(0, 1, 2, 3);          run_cal(1'b1); check_result();
    prep(4, 5, 6, 7);          run_cal(1'b0); check_result();
    prep(int'($urandom % 8), int'($urandom % 8), int'($urandom % 8), int'($urandom % 8));
    bad[2] = 1'b1;             run_cal(1'b0); check_result();
    prep(5, int'($urandom % 8), int'($urandom % 8), int'($urandom % 8));
    tmp_lane0 = 1'b1;
    tmp_until = ecnt + 42;     run_cal(1'b0); check_result();
    for (int r = 0; r < 4; r++) begin
      prep(int'($urandom % 8), int'($urandom % 8), int'($urandom % 8), int'($urandom % 8));
      for (int l = 0; l < LANES; l++) bad[l] = ($urandom % 5 == 0);
      run_cal(r[0]); check_result();
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule